// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends one smart card character per request over a single open-drain style data line, in the mode where a character is never repeated. A byte is handed over with a one-cycle start strobe while the block reports itself ready. The block then drives a low start bit, the eight data bits and one parity bit. Bit timing is derived from a basic-clock enable pulse that the surrounding logic supplies. The elementary time unit (etu) is a selectable whole number of those pulses.

Two conventions are supported. In the direct convention, data leaves least significant bit first at its true level. In the inverse convention, data leaves most significant bit first with every data bit complemented. The parity bit is never complemented by the convention logic. A separate odd/even control flips its sense, so that the inverse convention still yields even parity on the line.

After the parity bit, the line is held high for a guard interval. The block then raises both its ready output and a transmit-end flag exactly 11.5 etu after the start bit began. The flag stays set until the next byte is accepted.

Top module: `sc_tx_char`

## Requirements
- R1: After reset, and whenever the block is idle, `tx_line` is high, `tx_ready` is 1 and `tx_end` is 0 until a first character completes.
- R2: One etu lasts a number of `bclk_en` pulses chosen by `etu_sel`: 0 gives 32, 1 gives 64, 2 gives 372 and 3 gives 256.
- R3: A clock edge with `tx_start` and `tx_ready` both high captures `tx_data`. In the following cycle `tx_ready` is 0 and `tx_line` is low (start bit) for exactly one etu.
- R4: With `inv_conv` = 0, the eight etu after the start bit carry data bit 0 through bit 7 in that order, and the line level equals the bit value.
- R5: With `inv_conv` = 1, the eight etu after the start bit carry data bit 7 down to bit 0, and the line level is the complement of each bit.
- R6: The tenth etu after the start carries the parity bit. Its level is the XOR of the eight captured data bits XOR `odd_par`, whatever the convention.
- R7: After the parity bit the line stays high, and `tx_ready` stays 0, for 1.5 etu (a guard of at least one etu).
- R8: `tx_end` rises together with `tx_ready`, 11.5 etu of pulses after the start bit began. It stays 1 while idle and is cleared in the cycle after the next byte is accepted.
- R9: `tx_start` while `tx_ready` is 0 is ignored: the character in progress continues unchanged.
- R10: The line changes only in the cycle after an accept or after a cycle with `bclk_en` high. With `bclk_en` low, bit timing stalls.
- R11: `etu_sel`, `inv_conv`, `odd_par` and `tx_data` are sampled only at acceptance. Changing them during a character has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_en | input | 1 | Basic-clock enable pulse, one per basic clock period |
| etu_sel | input | 2 | Etu length select (32/64/372/256 pulses) |
| inv_conv | input | 1 | 0 direct convention, 1 inverse convention |
| odd_par | input | 1 | Flips parity sense when 1 |
| tx_start | input | 1 | Start strobe, accepted when `tx_ready` is 1 |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Idle and guard time over; a byte may be accepted |
| tx_line | output | 1 | Serial data line, high when idle |
| tx_end | output | 1 | Transmit-end flag |

## Verification
Every cycle, the assertions check that the line is high while idle, that an accept yields a start bit, a clear end flag and a busy state, and that the line holds through cycles without a basic-clock pulse. They also check that a busy-time start strobe is ignored and that the end flag rises only as the block leaves its busy state. The data bit order, the inversion, the parity value and the exact etu and 11.5 etu durations depend on the captured byte and on pulse counts. Only the bench's sweeps over all four etu lengths, both conventions, both parity senses, many data values and stalled pulse patterns can show these.

// File: rtl/sc_tx_pkg.sv
// Package: shared constants and helpers for the smart card character transmitter.
// Assumes 8-bit characters and four etu lengths selected by a 2-bit code.
package sc_tx_pkg;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_ETU0   = 32;
    localparam int DEF_ETU1   = 64;
    localparam int DEF_ETU2   = 372;
    localparam int DEF_ETU3   = 256;

    typedef logic [1:0] etu_sel_t;

    // Largest of four etu lengths, used to size the pulse counter.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/sc_etu_timer.sv
// Module: counts basic-clock enable pulses and flags the last pulse of a slot.
// Assumes limit >= 1 and stays constant within a slot; clr holds the count at zero.
module sc_etu_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bclk_en,
    input  logic [CNT_W-1:0] limit,
    output logic             slot_done
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    // Last pulse of the current slot.
    always_comb at_last = (cnt_q == (limit - CNT_W'(1)));

    assign slot_done = bclk_en && at_last;

    // Pulse counter, wraps at the end of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (bclk_en) begin
            cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sc_char_fmt.sv
// Module: chooses the line level for the current slot of a character.
// Slot 0 is the start bit, 1..DATA_W the data bits, DATA_W+1 parity, later slots guard.
// Assumes data and controls are held stable for the whole character.
module sc_char_fmt #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              busy,
    input  logic [IDX_W-1:0]  slot,
    input  logic [DATA_W-1:0] data,
    input  logic              inv_conv,
    input  logic              odd_par,
    output logic              line
);
    localparam int PAR_SLOT = DATA_W + 1;

    logic [DATA_W-1:0] ordered;
    logic              par_bit;

    // Reorder and invert data according to the convention.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            ordered[i] = inv_conv ? ~data[DATA_W-1-i] : data[i];
        end
    end

    // Even parity over true data, sense flipped by odd_par only.
    always_comb par_bit = (^data) ^ odd_par;

    // Line level per slot; high when idle or in guard.
    always_comb begin
        line = 1'b1;
        if (busy) begin
            if (slot == '0) begin
                line = 1'b0;
            end else if (int'(slot) <= DATA_W) begin
                line = ordered[int'(slot) - 1];
            end else if (int'(slot) == PAR_SLOT) begin
                line = par_bit;
            end
        end
    end
endmodule

// File: rtl/sc_tx_char.sv
// Module: smart card character transmitter without retransmission.
// Accepts a byte when idle, sends start, data, parity, holds a 1.5 etu guard,
// then raises ready and the end flag together 11.5 etu after the start bit.
// Assumes bclk_en is a single-cycle pulse train from an external baud source.
module sc_tx_char
    import sc_tx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ETU0   = DEF_ETU0,
    parameter int ETU1   = DEF_ETU1,
    parameter int ETU2   = DEF_ETU2,
    parameter int ETU3   = DEF_ETU3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_en,
    input  logic [1:0]        etu_sel,
    input  logic              inv_conv,
    input  logic              odd_par,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              tx_line,
    output logic              tx_end
);
    localparam int CNT_W     = $clog2(max4(ETU0, ETU1, ETU2, ETU3) + 1);
    localparam int LAST_SLOT = DATA_W + 3;
    localparam int IDX_W     = $clog2(LAST_SLOT + 1);

    logic              busy_q;
    logic [IDX_W-1:0]  slot_q;
    logic [DATA_W-1:0] data_q;
    logic              inv_q;
    logic              odd_q;
    etu_sel_t          sel_q;
    logic              end_q;
    logic [CNT_W-1:0]  etu_full;
    logic [CNT_W-1:0]  slot_limit;
    logic              slot_done;
    logic              accept;
    logic              in_last;

    assign accept   = tx_start && !busy_q;
    assign in_last  = (slot_q == IDX_W'(LAST_SLOT));
    assign tx_ready = !busy_q;
    assign tx_end   = end_q;

    // Etu length from the latched select.
    always_comb begin
        case (sel_q)
            2'd0:    etu_full = CNT_W'(ETU0);
            2'd1:    etu_full = CNT_W'(ETU1);
            2'd2:    etu_full = CNT_W'(ETU2);
            default: etu_full = CNT_W'(ETU3);
        endcase
    end

    // Final guard slot lasts half an etu.
    always_comb slot_limit = in_last ? (etu_full >> 1) : etu_full;

    sc_etu_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!busy_q),
        .bclk_en   (bclk_en),
        .limit     (slot_limit),
        .slot_done (slot_done)
    );

    sc_char_fmt #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fmt (
        .busy     (busy_q),
        .slot     (slot_q),
        .data     (data_q),
        .inv_conv (inv_q),
        .odd_par  (odd_q),
        .line     (tx_line)
    );

    // Character sequencer: accept, step slots, finish with end flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            slot_q <= '0;
            data_q <= '0;
            inv_q  <= 1'b0;
            odd_q  <= 1'b0;
            sel_q  <= '0;
            end_q  <= 1'b0;
        end else if (accept) begin
            busy_q <= 1'b1;
            slot_q <= '0;
            data_q <= tx_data;
            inv_q  <= inv_conv;
            odd_q  <= odd_par;
            sel_q  <= etu_sel;
            end_q  <= 1'b0;
        end else if (busy_q && slot_done) begin
            if (in_last) begin
                busy_q <= 1'b0;
                slot_q <= '0;
                end_q  <= 1'b1;
            end else begin
                slot_q <= slot_q + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/sc_tx_char_chk.sv
// Module: protocol checker for sc_tx_char, bound to every instance.
// Assumes synchronous active-low reset held for at least one clock at start.
module sc_tx_char_chk (
    input logic clk,
    input logic rst_n,
    input logic bclk_en,
    input logic tx_start,
    input logic tx_ready,
    input logic tx_line,
    input logic tx_end
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_line); // R1

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && tx_ready) |=> (!tx_ready && !tx_line && !tx_end)); // R3

    AST_END_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |-> tx_ready); // R8

    AST_END_RISES_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end) |-> $rose(tx_ready)); // R8

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && !tx_ready && !bclk_en) |=> (!tx_ready && $stable(tx_line))); // R9

    AST_LINE_HOLDS_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && !bclk_en) |=> $stable(tx_line)); // R10

    AST_FINISH_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && !bclk_en) |=> !tx_ready); // R10
endmodule

bind sc_tx_char sc_tx_char_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_en  (bclk_en),
    .tx_start (tx_start),
    .tx_ready (tx_ready),
    .tx_line  (tx_line),
    .tx_end   (tx_end)
);

// File: tb/sc_tx_char_bench.sv
`timescale 1ns/1ps
// Bench: sweeps etu lengths, conventions, parity sense and data values,
// computing every expected line level and duration from the requirements.
module sc_tx_char_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bclk_en;
    logic [1:0] etu_sel;
    logic       inv_conv;
    logic       odd_par;
    logic       tx_start;
    logic [7:0] tx_data;
    logic       tx_ready;
    logic       tx_line;
    logic       tx_end;
    int         checks   = 0;
    int         failures = 0;

    always #2 clk = ~clk;

    sc_tx_char u_sc_tx_char (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_en  (bclk_en),
        .etu_sel  (etu_sel),
        .inv_conv (inv_conv),
        .odd_par  (odd_par),
        .tx_start (tx_start),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .tx_line  (tx_line),
        .tx_end   (tx_end)
    );

    // Record one check; report on failure.
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int etu_of(input logic [1:0] s);
        case (s)
            2'd0:    return 32;
            2'd1:    return 64;
            2'd2:    return 372;
            default: return 256;
        endcase
    endfunction

    // One clock with the given enable, ending at the next falling edge.
    task automatic cyc(input logic en);
        bclk_en = en;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Send one character and check every slot at the ports.
    task automatic send(input logic [7:0] d, input logic [1:0] s,
                        input logic cv, input logic od, input bit stall);
        logic [9:0] exp;
        int         len;
        bit         bad;
        bit         bad_stall;
        string      req;
        len    = etu_of(s);
        exp[0] = 1'b0;
        for (int k = 1; k <= 8; k++) exp[k] = cv ? ~d[8-k] : d[k-1];
        exp[9] = (^d) ^ od;
        chk(tx_ready == 1'b1, "R3", "ready before accept", int'(tx_ready), 1);
        tx_data = d; etu_sel = s; inv_conv = cv; odd_par = od;
        tx_start = 1'b1;
        cyc(1'b0);
        tx_start = 1'b0;
        // R11: disturb all sampled inputs during the character.
        tx_data = ~d; etu_sel = s ^ 2'd1; inv_conv = ~cv; odd_par = ~od;
        chk(tx_ready == 1'b0 && tx_line == 1'b0, "R3", "start after accept",
            int'({tx_ready, tx_line}), 0);
        chk(tx_end == 1'b0, "R8", "end cleared on accept", int'(tx_end), 0);
        bad_stall = 1'b0;
        for (int k = 0; k < 10; k++) begin
            bad = 1'b0;
            for (int p = 0; p < len; p++) begin
                if (stall) begin
                    if (k == 4 && p == 1) tx_start = 1'b1; // R9 strobe while busy
                    cyc(1'b0);
                    tx_start = 1'b0;
                    if (tx_line !== exp[k] || tx_ready !== 1'b0) bad_stall = 1'b1;
                end
                if (tx_line !== exp[k]) bad = 1'b1;
                if (!stall && k == 4 && p == 1) tx_start = 1'b1; // R9
                cyc(1'b1);
                tx_start = 1'b0;
            end
            if (k == 0) req = "R2";
            else if (k == 9) req = "R6";
            else req = cv ? "R5" : "R4";
            chk(!bad, req, $sformatf("slot %0d level/duration (R9 R11)", k),
                int'(tx_line), int'(exp[k]));
        end
        bad = 1'b0;
        for (int p = 0; p < len + len / 2; p++) begin
            if (stall) begin
                cyc(1'b0);
                if (tx_ready !== 1'b0) bad_stall = 1'b1;
            end
            if (tx_line !== 1'b1 || tx_ready !== 1'b0 || tx_end !== 1'b0) bad = 1'b1;
            cyc(1'b1);
        end
        chk(!bad, "R7", "guard high and busy", int'(tx_line), 1);
        if (stall) chk(!bad_stall, "R10", "stall holds state", 1, 0);
        chk(tx_ready == 1'b1 && tx_end == 1'b1, "R8", "end at 11.5 etu (R2)",
            int'({tx_ready, tx_end}), 3);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bclk_en = 1'b0; etu_sel = 2'd0; inv_conv = 1'b0;
        odd_par = 1'b0; tx_start = 1'b0; tx_data = 8'h00;
        repeat (3) @(negedge clk);
        chk(tx_line == 1'b1 && tx_ready == 1'b1 && tx_end == 1'b0, "R1",
            "reset state", int'({tx_line, tx_ready, tx_end}), 6);
        rst_n = 1'b1;
        cyc(1'b1); cyc(1'b1);
        chk(tx_line == 1'b1 && tx_ready == 1'b1 && tx_end == 1'b0, "R1",
            "idle after reset", int'({tx_line, tx_ready, tx_end}), 6);
        // Sweep of all etu lengths, conventions and parity senses.
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int o = 0; o < 2; o++) begin
                    send(8'h3B ^ 8'(s * 16 + c * 5 + o), 2'(s), c[0], o[0],
                         (s == 3) || (s == 0 && c == 1));
                end
            end
        end
        // Idle: end flag holds, line high.
        repeat (3) cyc(1'b1);
        chk(tx_end == 1'b1 && tx_line == 1'b1, "R8", "end holds while idle",
            int'({tx_end, tx_line}), 3);
        // Data sweep on the short etu lengths.
        for (int i = 0; i < 64; i++) begin
            send(8'(i * 37 + 5), 2'(i % 2), i[1], i[2], i[3] && i[0]);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule